// File: doc/BRIEF.md
# Page Access Permission Check and Fault Recorder

This block sits behind a page-table walker. It takes one translated access per transaction and decides whether it may proceed. The request carries the kind of access (read, write, instruction fetch, or write with fetch), whether it comes from user or supervisor state, the 3-bit permission code of the final page entry, that entry's modified bit, any fault the walker has already found, the no-fault mode bit, the trap-enable bit and the full virtual address. The block packs the access kind and privilege into a 3-bit index. From the index and the permission code it derives an access error, then produces a fault flag, an error word, the granted read/write/execute rights and a trap request.

The block also holds a fault status register and a fault address register. Each recorded fault writes the status with the access index, the fault type, the walk level and a valid bit. If an earlier fault is still unread, the status first collapses to an overflow marker. A status read through the register port clears it.

Requests enter on a valid/ready port and results leave on a valid/ready port. A new request is accepted when the result slot is empty or is being drained in the same cycle. A result stays on the outputs, unchanged, for as long as `rsp_ready` is low.

Top module: `mmu_access_guard`

## Requirements
- R1: The access index has bit 2 set for a write, bit 1 set for a fetch and bit 0 set for a supervisor access. It is recorded in status bits 7:5.
- R2: The access fault type is 3 (privilege) for a user access to permission code 6 or 7. Otherwise it is 2 (protection) when the needed rights are not all present, and 0 otherwise. A plain read needs R, a write needs W and a fetch needs X. Rights {X,W,R} per code for supervisor: 0:R 1:RW 2:RX 3:RWX 4:X 5:RW 6:RX 7:RWX. User rights are the same for codes 0 to 4; code 5 gives R only, and codes 6 and 7 give nothing. The error word carries the fault type in bits 4:2.
- R3: In no-fault mode, a nonzero access fault type on a user access does not block the access. The fault is still recorded.
- R4: When the access is not blocked, `rsp_grant` ({X,W,R}) equals the rights from R2, with W cleared when the modified bit is 0.
- R5: A nonzero walker fault type takes precedence over the permission check. The access is blocked, and the error word is level in bits 9:8 and walker type in bits 4:2.
- R6: On any nonzero error word, the new status is built from a base value: the base is zero if the status is being read in that cycle, and the current status otherwise. The new status is (base ≠ 0 ? 1 : 0) | index<<5 | error word | 2.
- R7: Every recorded fault loads the full virtual address into the address register. Without a fault, the address register keeps its value.
- R8: A blocked access with no-fault mode off and traps enabled raises `rsp_trap_fetch` for fetches and `rsp_trap_data` otherwise, and grants nothing. With no-fault mode on or traps disabled, a blocked access raises no trap and grants RWX.
- R9: `rd_data` shows the status (zero-extended) when `rd_sel`=0 and the fault address when `rd_sel`=1. A status read with `rd_en` clears the status at that edge unless a fault is recorded in the same edge.
- R10: Both registers and `rsp_valid` reset to zero. The registers update at the same edge that accepts the faulting request.
- R11: `req_ready` is high when `rsp_valid` is low or `rsp_ready` is high. While `rsp_valid` is high and `rsp_ready` is low, all response fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | Access writes |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_user | input | 1 | Access from user state |
| req_perm | input | 3 | Page permission code |
| req_modified | input | 1 | Page modified bit |
| req_walk_type | input | 3 | Walker fault type, 0 = none |
| req_walk_level | input | 2 | Walk level of the walker fault |
| req_nofault | input | 1 | No-fault mode |
| req_traps_en | input | 1 | Traps enabled |
| req_vaddr | input | VA_W | Virtual address |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken |
| rsp_fault | output | 1 | Access blocked |
| rsp_err | output | 10 | Error word |
| rsp_grant | output | 3 | Granted rights {X,W,R} |
| rsp_trap_fetch | output | 1 | Instruction access exception |
| rsp_trap_data | output | 1 | Data access exception |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | 0 = status, 1 = fault address |
| rd_data | output | VA_W | Register read data |

## Verification
A wrong entry in the permission logic shows at once on `rsp_err` and `rsp_grant`, in the cycle after the request is accepted. A wrong status value is harder to spot, because it hides in the status register until the next read. A missed clear or a spurious overflow only appears as bit 0 of the status after a later fault. For this reason, each sweep step reads both registers right after the result, and the read-and-clear is placed so that some faults land on a clean status and some on a dirty one.

// File: rtl/mmu_guard_pkg.sv
package mmu_guard_pkg;
  localparam int PERM_W  = 3;
  localparam int NPERM   = 1 << PERM_W;
  localparam int IDX_W   = 3;
  localparam int FT_W    = 3;
  localparam int LVL_W   = 2;
  localparam int FT_LSB  = 2;
  localparam int IDX_LSB = FT_LSB + FT_W;
  localparam int LVL_LSB = IDX_LSB + IDX_W;
  localparam int ERR_W   = LVL_LSB + LVL_W;

  localparam logic [FT_W-1:0] FT_NONE = 3'd0;
  localparam logic [FT_W-1:0] FT_PROT = 3'd2;
  localparam logic [FT_W-1:0] FT_PRIV = 3'd3;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } rights_t;

  function automatic rights_t sup_rights(input int p);
    rights_t t;
    t.r = (p != 4);
    t.w = (p % 2) == 1;
    t.x = ((p / 2) % 2 == 1) || (p == 4);
    return t;
  endfunction

  function automatic rights_t usr_rights(input int p);
    rights_t t;
    if (p >= 6)      t = '0;
    else if (p == 5) t = '{x: 1'b0, w: 1'b0, r: 1'b1};
    else             t = sup_rights(p);
    return t;
  endfunction
endpackage

// File: rtl/mmu_acc_index.sv
module mmu_acc_index
  import mmu_guard_pkg::*;
(
  input  logic             is_write,
  input  logic             is_fetch,
  input  logic             is_user,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx    = '0;
    idx[2] = is_write;
    idx[1] = is_fetch;
    idx[0] = ~is_user;
  end
endmodule

// File: rtl/mmu_perm_check.sv
module mmu_perm_check
  import mmu_guard_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  input  logic [PERM_W-1:0] perm,
  input  logic              modified,
  output logic [FT_W-1:0]   ftype,
  output rights_t           grant
);
  rights_t sup_tbl [NPERM];
  rights_t usr_tbl [NPERM];

  for (genvar p = 0; p < NPERM; p++) begin : g_rights
    assign sup_tbl[p] = sup_rights(p);
    assign usr_tbl[p] = usr_rights(p);
  end

  logic    user;
  rights_t have;
  rights_t need;

  always_comb begin
    user   = ~idx[0];
    have   = user ? usr_tbl[perm] : sup_tbl[perm];
    need.r = ~idx[2] & ~idx[1];
    need.w = idx[2];
    need.x = idx[1];
    if (user && perm[2] && perm[1])
      ftype = FT_PRIV;
    else if ((need & ~have) != '0)
      ftype = FT_PROT;
    else
      ftype = FT_NONE;
    grant   = have;
    grant.w = have.w & modified;
  end
endmodule

// File: rtl/mmu_fault_regs.sv
module mmu_fault_regs
  import mmu_guard_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rec_en,
  input  logic [ERR_W-1:0] rec_word,
  input  logic [VA_W-1:0]  rec_vaddr,
  input  logic             clr,
  output logic [ERR_W-1:0] status,
  output logic [VA_W-1:0]  fault_addr
);
  logic [ERR_W-1:0] base;
  logic [ERR_W-1:0] ovf;
  localparam logic [ERR_W-1:0] VALID_BIT = ERR_W'(2);

  always_comb begin
    base = clr ? '0 : status;
    ovf  = (base != '0) ? ERR_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status     <= '0;
      fault_addr <= '0;
    end else if (rec_en) begin
      status     <= ovf | rec_word | VALID_BIT;
      fault_addr <= rec_vaddr;
    end else if (clr) begin
      status <= '0;
    end
  end

  assert_valid_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rec_en |=> status[1]);
  assert_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_en && !clr && status != '0) |=> status[0]);
  assert_addr_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rec_en |=> fault_addr == $past(rec_vaddr));
  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_en |=> $stable(fault_addr));
  assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !rec_en) |=> status == '0);
endmodule

// File: rtl/mmu_access_guard.sv
module mmu_access_guard
  import mmu_guard_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic                 req_fetch,
  input  logic                 req_user,
  input  logic [PERM_W-1:0]    req_perm,
  input  logic                 req_modified,
  input  logic [FT_W-1:0]      req_walk_type,
  input  logic [LVL_W-1:0]     req_walk_level,
  input  logic                 req_nofault,
  input  logic                 req_traps_en,
  input  logic [VA_W-1:0]      req_vaddr,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic                 rsp_fault,
  output logic [ERR_W-1:0]     rsp_err,
  output logic [2:0]           rsp_grant,
  output logic                 rsp_trap_fetch,
  output logic                 rsp_trap_data,
  input  logic                 rd_en,
  input  logic                 rd_sel,
  output logic [VA_W-1:0]      rd_data
);
  logic [IDX_W-1:0] idx;
  logic [FT_W-1:0]  acc_ft;
  rights_t          page_grant;
  logic [ERR_W-1:0] status;
  logic [VA_W-1:0]  fault_addr;

  mmu_acc_index u_idx (
    .is_write (req_write),
    .is_fetch (req_fetch),
    .is_user  (req_user),
    .idx      (idx)
  );

  mmu_perm_check u_perm (
    .idx      (idx),
    .perm     (req_perm),
    .modified (req_modified),
    .ftype    (acc_ft),
    .grant    (page_grant)
  );

  logic             accept, walk_bad, acc_bad, blocked, lenient, record;
  logic [ERR_W-1:0] err_word, stat_word;
  logic [2:0]       grant_n;

  always_comb begin
    req_ready = ~rsp_valid | rsp_ready;
    accept    = req_valid & req_ready;
    walk_bad  = req_walk_type != '0;
    acc_bad   = acc_ft != FT_NONE;
    blocked   = walk_bad | (acc_bad & ~(req_nofault & req_user));
    lenient   = req_nofault | ~req_traps_en;
    record    = walk_bad | acc_bad;
    err_word  = '0;
    if (walk_bad) begin
      err_word[FT_LSB +: FT_W]   = req_walk_type;
      err_word[LVL_LSB +: LVL_W] = req_walk_level;
    end else begin
      err_word[FT_LSB +: FT_W]   = acc_ft;
    end
    stat_word = err_word;
    stat_word[IDX_LSB +: IDX_W] = idx;
    if (!blocked)     grant_n = page_grant;
    else if (lenient) grant_n = 3'b111;
    else              grant_n = 3'b000;
  end

  mmu_fault_regs #(.VA_W(VA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .rec_en     (accept & record),
    .rec_word   (stat_word),
    .rec_vaddr  (req_vaddr),
    .clr        (rd_en & ~rd_sel),
    .status     (status),
    .fault_addr (fault_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_fault      <= 1'b0;
      rsp_err        <= '0;
      rsp_grant      <= '0;
      rsp_trap_fetch <= 1'b0;
      rsp_trap_data  <= 1'b0;
    end else if (accept) begin
      rsp_valid      <= 1'b1;
      rsp_fault      <= blocked;
      rsp_err        <= err_word;
      rsp_grant      <= grant_n;
      rsp_trap_fetch <= blocked & ~lenient & req_fetch;
      rsp_trap_data  <= blocked & ~lenient & ~req_fetch;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_comb begin
    rd_data = rd_sel ? fault_addr : VA_W'(status);
  end

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_err) &&
      $stable(rsp_grant) && $stable(rsp_fault));
  assert_one_trap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_trap_fetch, rsp_trap_data}));
  assert_trap_nogrant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_trap_fetch || rsp_trap_data) |-> rsp_grant == 3'b000 && rsp_fault);
  assert_walk_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_walk_type != '0) |=> rsp_fault);
endmodule

// File: tb/tb_mmu_access_guard.sv
`timescale 1ns/1ps
module tb_mmu_access_guard;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid = 0, req_write = 0, req_fetch = 0, req_user = 0, req_modified = 0;
  logic req_nofault = 0, req_traps_en = 0, rsp_ready = 1, rd_en = 0, rd_sel = 0;
  logic [2:0] req_perm = 0, req_walk_type = 0;
  logic [1:0] req_walk_level = 0;
  logic [31:0] req_vaddr = 0;
  logic req_ready, rsp_valid, rsp_fault, rsp_trap_fetch, rsp_trap_data;
  logic [9:0] rsp_err;
  logic [2:0] rsp_grant;
  logic [31:0] rd_data;

  mmu_access_guard dut (.*);

  int tests = 0, fails = 0;
  logic [9:0]  m_fsr = 0;
  logic [31:0] m_far = 0;

  // Error table [index][perm] and rights {X,W,R} from the requirements
  logic [1:0] acc_tbl [8][8] = '{
    '{0,0,0,0,2,0,3,3}, '{0,0,0,0,2,0,0,0}, '{2,2,0,0,0,2,3,3}, '{2,2,0,0,0,2,0,0},
    '{2,0,2,0,2,2,3,3}, '{2,0,2,0,2,0,2,0}, '{2,2,2,0,2,2,3,3}, '{2,2,2,0,2,2,2,0}};
  logic [2:0] sup_tbl [8] = '{3'b001,3'b011,3'b101,3'b111,3'b100,3'b011,3'b101,3'b111};
  logic [2:0] usr_tbl [8] = '{3'b001,3'b011,3'b101,3'b111,3'b100,3'b001,3'b000,3'b000};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic f, input logic u, input logic [2:0] perm,
                        input logic mod, input logic [2:0] wt, input logic [1:0] wl,
                        input logic nf, input logic te, input logic [31:0] va, input logic clr);
    logic [2:0] idx, have, grant;
    logic [1:0] code;
    logic [9:0] err, base;
    logic blocked, lenient;
    idx = {w, f, ~u};
    code = acc_tbl[idx][perm];
    have = u ? usr_tbl[perm] : sup_tbl[perm];
    err = (wt != 0) ? {wl, 3'b000, wt, 2'b00} : {5'd0, 1'b0, code, 2'b00};
    blocked = (wt != 0) || (code != 0 && !(nf && u));
    lenient = nf || !te;
    grant = !blocked ? (have & (mod ? 3'b111 : 3'b101)) : (lenient ? 3'b111 : 3'b000);
    @(negedge clk);
    req_write = w; req_fetch = f; req_user = u; req_perm = perm; req_modified = mod;
    req_walk_type = wt; req_walk_level = wl; req_nofault = nf; req_traps_en = te;
    req_vaddr = va; req_valid = 1; rd_en = clr; rd_sel = 0;
    @(negedge clk);
    req_valid = 0; rd_en = 0;
    base = clr ? 10'd0 : m_fsr;
    if (err != 0) begin
      m_fsr = ((base != 0) ? 10'd1 : 10'd0) | {2'b00, idx, 5'd0} | err | 10'd2;
      m_far = va;
    end else if (clr) m_fsr = 0;
    check("R11 rsp_valid", rsp_valid, 1);
    check("R2/R5 rsp_err", rsp_err, err);
    check("R3/R5 rsp_fault", rsp_fault, blocked);
    check("R4/R8 rsp_grant", rsp_grant, grant);
    check("R8 trap", {rsp_trap_fetch, rsp_trap_data},
          {blocked && !lenient && f, blocked && !lenient && !f});
    rd_sel = 0; #0.1;
    check("R1/R6/R9 status", rd_data, {22'd0, m_fsr});
    rd_sel = 1; #0.1;
    check("R7 fault address", rd_data, m_far);
    rd_sel = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R10 rsp_valid reset", rsp_valid, 0);
    check("R10 status reset", rd_data, 0);
    rd_sel = 1; #0.1;
    check("R10 address reset", rd_data, 0);
    rd_sel = 0;
    rst_n = 1;
    n = 0;
    // R1 R2 R3 R4 R6 R8 sweep
    for (int i = 0; i < 8; i++)
      for (int p = 0; p < 8; p++)
        for (int m = 0; m < 2; m++)
          for (int md = 0; md < 4; md++) begin
            n++;
            access(i[2], i[1], ~i[0], p[2:0], m[0], 3'd0, 2'd0, md[1], md[0],
                   32'h9E37_79B9 * n, (n % 3) == 0);
          end
    // R5 walker faults at several levels and types
    for (int t = 1; t < 8; t++)
      for (int l = 0; l < 4; l++)
        access(t[0], t[1], l[0], 3'd3, 1'b1, t[2:0], l[1:0], l[1], 1'b1,
               32'hC0DE_0000 + t * 16 + l, l == 2);
    // R9 clear-only read
    @(negedge clk); rd_en = 1; rd_sel = 0;
    @(negedge clk); rd_en = 0; m_fsr = 0; #0.1;
    check("R9 status cleared by read", rd_data, 0);
    // R9 read of address register has no side effect
    access(1'b0, 1'b1, 1'b1, 3'd6, 1'b0, 3'd0, 2'd0, 1'b0, 1'b1, 32'h1234_5678, 1'b0);
    @(negedge clk); rd_en = 1; rd_sel = 1;
    @(negedge clk); rd_en = 0; rd_sel = 0; #0.1;
    check("R9 status kept after address read", rd_data, {22'd0, m_fsr});
    // R11 back-pressure
    rsp_ready = 0;
    access(1'b1, 1'b0, 1'b1, 3'd0, 1'b1, 3'd0, 2'd0, 1'b0, 1'b1, 32'hAAAA_0001, 1'b1);
    req_write = 0; req_fetch = 0; req_user = 0; req_perm = 3'd4; req_vaddr = 32'hBBBB_0002;
    req_valid = 1; #0.1;
    check("R11 ready low when full", req_ready, 0);
    repeat (3) @(negedge clk);
    check("R11 err held", rsp_err, 10'h008);
    check("R11 valid held", rsp_valid, 1);
    rd_sel = 1; #0.1;
    check("R11 held request not recorded", rd_data, 32'hAAAA_0001);
    rd_sel = 0;
    rsp_ready = 1;
    @(negedge clk); req_valid = 0;
    check("R2 drained request err", rsp_err, 10'h008);
    rd_sel = 1; #0.1;
    check("R7 address after drain", rd_data, 32'hBBBB_0002);
    rd_sel = 0;
    @(negedge clk);
    check("R11 valid drops when drained", rsp_valid, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule